// File: doc/BRIEF.md
# Dual-Cluster Reset and Configuration Register Slave

This block is a word-addressed register slave with a 4 KB window, 12 address bits. Software uses it to hold individual resets in two processor clusters and to read which of those resets are active. It also prepares the static configuration-pin values that each cluster samples.

A configuration value written by software is kept in a staging register. It reaches the cluster's pins only when that cluster is next released from reset. The block also raises a one-cycle system reset request when software writes a nonzero value to a dedicated command register. It drives an 8-bit indicator output, reads back an 8-bit switch input, and returns two constant identification words.

The bus side is a single-cycle request with a valid/ready pair. The block accepts a request on every cycle. One cycle after each request it returns a registered response that carries read data and an error flag.

Top module: `cluster_cfg_regs`

## Requirements
- R1: After reset, the following values hold. Every cluster reset output is 0. Cluster 0 applies configuration 0x00000 and cluster 1 applies 0x10000. The indicator output is 0, the system reset request is 0 and no response is valid.
- R2: `req_ready` is always 1. A request sampled with `req_valid` high at a clock edge gives `rsp_valid` high for the following cycle. A cycle with no request gives `rsp_valid` low in the next cycle.
- R3: An access inside the window to an offset that has no register returns `rsp_err`=1 with read data 0 and changes no state.
- R4: An access whose `req_size` is not 2'b10 (a 32-bit word) returns `rsp_err`=1 and is not performed. An access whose address is not a multiple of 4 is handled the same way.
- R5: The reset-hold registers sit at offset 0x000 for cluster 0 and 0x004 for cluster 1. Each is 9 bits wide and read/write, and bits 31:9 read as 0. Cluster c drives its value on `cl_rst_o[9c+8:9c]` from the cycle after the write.
- R6: The status registers at 0x00C (cluster 0) and 0x010 (cluster 1) read as the hold bits ORed with `sys_rst_i` in all 9 positions. A write to them is ignored and returns no error.
- R7: The staged configuration registers sit at 0x024 (cluster 0) and 0x02C (cluster 1). Each is 20 bits wide, read/write, and resets to 0x00000 and 0x10000 respectively. A write to one of them does not change `cl_cfg_o`. The applied value for cluster c, on `cl_cfg_o[20c+19:20c]`, takes the staged value only on the edge where hold bit 0 of that cluster goes from 1 to 0.
- R8: The applied configuration reads back at 0x020 (cluster 0) and 0x028 (cluster 1). A write to these offsets is ignored and returns no error.
- R9: A write to 0x008 whose bits 23:0 are not all zero raises `sys_rst_req_o` for exactly the one cycle after the write. A write whose bits 23:0 are zero produces no request. A read of 0x008 returns 0.
- R10: The indicator register at 0x104 is 8 bits wide, read/write, and drives `led_o`. The offset 0x108 reads `sw_i`, and a write there is ignored.
- R11: Offset 0xFF8 reads the parameter `AUX_ID` and offset 0xFFC reads the parameter `MAIN_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 2 | Access size; 2'b10 = word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data (0 on writes and errors) |
| sys_rst_i | input | 1 | Global system reset, used in the status view |
| sw_i | input | 8 | Switch inputs |
| cl_rst_o | output | 18 | Reset-hold bits, 9 per cluster |
| cl_cfg_o | output | 40 | Applied configuration, 20 per cluster |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| led_o | output | 8 | Indicator output |

## Verification
A request is captured at one rising edge. Its response, the register update it causes, any change to the applied configuration and any system reset request all appear after that same edge. The system reset request drops again after the next edge. The bench drives inputs on the falling edge, waits for one rising edge, and then samples both the response and the outputs on the next falling edge. To confirm that a pulse is one cycle long, it looks at the request output again one falling edge later. To show that an ignored write or a rejected access has no effect, the bench reads the affected state back through the bus, or observes the output that state drives.

// File: rtl/cluster_cfg_pkg.sv
package cluster_cfg_pkg;
    localparam int NUM_CL   = 2;
    localparam int CL_IDX_W = (NUM_CL > 1) ? $clog2(NUM_CL) : 1;
    localparam int RST_W    = 9;
    localparam int CFG_W    = 20;
    localparam int SWRST_W  = 24;
    localparam int LED_W    = 8;
    localparam int SW_W     = 8;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    localparam logic [ADDR_W-1:0] OFS_HOLD_BASE = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_STAT_BASE = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_CFGR_BASE = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CFGW_BASE = 12'h024;
    localparam int HOLD_STRIDE = 4;
    localparam int STAT_STRIDE = 4;
    localparam int CFG_STRIDE  = 8;

    localparam logic [ADDR_W-1:0] OFS_SWRST = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_LED   = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_SW    = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_AID   = 12'hFF8;
    localparam logic [ADDR_W-1:0] OFS_ID    = 12'hFFC;

    typedef enum logic [3:0] {
        RK_NONE, RK_HOLD, RK_STAT, RK_CFGR, RK_CFGW,
        RK_SWRST, RK_LED, RK_SW, RK_AID, RK_ID
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [CL_IDX_W-1:0]   cl;
        logic                  err;
    } dec_t;

    function automatic logic [ADDR_W-1:0] ofs_at(input logic [ADDR_W-1:0] base,
                                                  input int stride, input int idx);
        return base + ADDR_W'(stride * idx);
    endfunction

    function automatic logic [CFG_W-1:0] cfg_reset_val(input int idx);
        return (idx == 1) ? CFG_W'(20'h10000) : '0;
    endfunction
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import cluster_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_t              dec_o
);
    reg_kind_e           kind;
    logic [CL_IDX_W-1:0] cl;
    logic                bad;

    always_comb begin
        kind = RK_NONE;
        cl   = '0;
        case (addr)
            OFS_SWRST: kind = RK_SWRST;
            OFS_LED:   kind = RK_LED;
            OFS_SW:    kind = RK_SW;
            OFS_AID:   kind = RK_AID;
            OFS_ID:    kind = RK_ID;
            default:   kind = RK_NONE;
        endcase
        for (int c = 0; c < NUM_CL; c++) begin
            if (addr == ofs_at(OFS_HOLD_BASE, HOLD_STRIDE, c)) begin
                kind = RK_HOLD; cl = CL_IDX_W'(c);
            end
            if (addr == ofs_at(OFS_STAT_BASE, STAT_STRIDE, c)) begin
                kind = RK_STAT; cl = CL_IDX_W'(c);
            end
            if (addr == ofs_at(OFS_CFGR_BASE, CFG_STRIDE, c)) begin
                kind = RK_CFGR; cl = CL_IDX_W'(c);
            end
            if (addr == ofs_at(OFS_CFGW_BASE, CFG_STRIDE, c)) begin
                kind = RK_CFGW; cl = CL_IDX_W'(c);
            end
        end
        bad   = (size != SIZE_WORD) || (kind == RK_NONE);
        dec_o = '{kind: (bad ? RK_NONE : kind), cl: cl, err: bad};
    end
endmodule

// File: rtl/ccr_cluster.sv
module ccr_cluster
    import cluster_cfg_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hold,
    input  logic             wr_cfg,
    input  logic [RST_W-1:0] hold_wdata,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [RST_W-1:0] hold_o,
    output logic [CFG_W-1:0] staged_o,
    output logic [CFG_W-1:0] applied_o
);
    localparam logic [CFG_W-1:0] CFG_RST = cfg_reset_val(IDX);

    logic [RST_W-1:0] hold_q, hold_d;
    logic [CFG_W-1:0] staged_q, applied_q;
    logic             release_now;

    always_comb begin
        hold_d      = wr_hold ? hold_wdata : hold_q;
        release_now = hold_q[0] & ~hold_d[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            staged_q  <= CFG_RST;
            applied_q <= CFG_RST;
        end else begin
            hold_q <= hold_d;
            if (wr_cfg)      staged_q  <= cfg_wdata;
            if (release_now) applied_q <= staged_q;
        end
    end

    assign hold_o    = hold_q;
    assign staged_o  = staged_q;
    assign applied_o = applied_q;

    // R7
    applied_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(applied_q) |-> ($past(hold_q[0]) && !hold_q[0]));

    // R5
    hold_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hold |=> $stable(hold_q));

    // R7
    staged_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cfg |=> $stable(staged_q));
endmodule

// File: rtl/cluster_cfg_regs.sv
module cluster_cfg_regs
    import cluster_cfg_pkg::*;
#(
    parameter logic [31:0] MAIN_ID = 32'h4C3A_0010,
    parameter logic [31:0] AUX_ID  = 32'h0000_0201
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [1:0]                req_size,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [DATA_W-1:0]         rsp_rdata,
    input  logic                      sys_rst_i,
    input  logic [SW_W-1:0]           sw_i,
    output logic [NUM_CL*RST_W-1:0]   cl_rst_o,
    output logic [NUM_CL*CFG_W-1:0]   cl_cfg_o,
    output logic                      sys_rst_req_o,
    output logic [LED_W-1:0]          led_o
);
    dec_t             dec;
    logic             wr_ok, rd_ok;
    logic [RST_W-1:0] hold_a    [NUM_CL];
    logic [CFG_W-1:0] staged_a  [NUM_CL];
    logic [CFG_W-1:0] applied_a [NUM_CL];
    logic [DATA_W-1:0] rdata_d;
    logic [LED_W-1:0]  led_q;
    logic              swrst_q;
    logic              rsp_valid_q, rsp_err_q;
    logic [DATA_W-1:0] rsp_rdata_q;
    logic              wdata_unused;

    assign wdata_unused = ^req_wdata[DATA_W-1:SWRST_W];
    assign req_ready    = 1'b1;

    ccr_decode u_decode (
        .addr  (req_addr),
        .size  (req_size),
        .dec_o (dec)
    );

    assign wr_ok = req_valid &  req_write & ~dec.err;
    assign rd_ok = req_valid & ~req_write & ~dec.err;

    for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
        logic wr_hold_c, wr_cfg_c;
        assign wr_hold_c = wr_ok && (dec.kind == RK_HOLD) && (dec.cl == CL_IDX_W'(c));
        assign wr_cfg_c  = wr_ok && (dec.kind == RK_CFGW) && (dec.cl == CL_IDX_W'(c));

        ccr_cluster #(.IDX(c)) u_cluster (
            .clk        (clk),
            .rst        (rst),
            .wr_hold    (wr_hold_c),
            .wr_cfg     (wr_cfg_c),
            .hold_wdata (req_wdata[RST_W-1:0]),
            .cfg_wdata  (req_wdata[CFG_W-1:0]),
            .hold_o     (hold_a[c]),
            .staged_o   (staged_a[c]),
            .applied_o  (applied_a[c])
        );

        assign cl_rst_o[c*RST_W +: RST_W] = hold_a[c];
        assign cl_cfg_o[c*CFG_W +: CFG_W] = applied_a[c];
    end

    always_comb begin
        case (dec.kind)
            RK_HOLD: rdata_d = DATA_W'(hold_a[dec.cl]);
            RK_STAT: rdata_d = DATA_W'(hold_a[dec.cl] | {RST_W{sys_rst_i}});
            RK_CFGR: rdata_d = DATA_W'(applied_a[dec.cl]);
            RK_CFGW: rdata_d = DATA_W'(staged_a[dec.cl]);
            RK_LED:  rdata_d = DATA_W'(led_q);
            RK_SW:   rdata_d = DATA_W'(sw_i);
            RK_AID:  rdata_d = AUX_ID;
            RK_ID:   rdata_d = MAIN_ID;
            default: rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q       <= '0;
            swrst_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            if (wr_ok && dec.kind == RK_LED) led_q <= req_wdata[LED_W-1:0];
            swrst_q     <= wr_ok && (dec.kind == RK_SWRST) && (|req_wdata[SWRST_W-1:0]);
            rsp_valid_q <= req_valid;
            rsp_err_q   <= req_valid & dec.err;
            rsp_rdata_q <= rd_ok ? rdata_d : '0;
        end
    end

    assign rsp_valid     = rsp_valid_q;
    assign rsp_err       = rsp_err_q;
    assign rsp_rdata     = rsp_rdata_q;
    assign sys_rst_req_o = swrst_q;
    assign led_o         = led_q;

    // R2
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R3
    err_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R9
    swrst_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req_o |-> $past(req_valid && req_write));

    // R10
    led_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> $stable(led_o));
endmodule

// File: tb/cluster_cfg_regs_bench.sv
`timescale 1ns/1ps
module cluster_cfg_regs_bench;
    localparam logic [31:0] T_MAIN_ID = 32'h1234_ABCD;
    localparam logic [31:0] T_AUX_ID  = 32'h0BAD_F00D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        sys_rst_i = 1'b0;
    logic [7:0]  sw_i = '0;
    logic [17:0] cl_rst_o;
    logic [39:0] cl_cfg_o;
    logic        sys_rst_req_o;
    logic [7:0]  led_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    cluster_cfg_regs #(.MAIN_ID(T_MAIN_ID), .AUX_ID(T_AUX_ID)) u_cluster_cfg_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .sys_rst_i(sys_rst_i), .sw_i(sw_i),
        .cl_rst_o(cl_rst_o), .cl_cfg_o(cl_cfg_o), .sys_rst_req_o(sys_rst_req_o),
        .led_o(led_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic wr_ok(input string tag, input logic [11:0] a, input logic [31:0] wd);
        logic [31:0] rd; logic er;
        access(1'b1, a, 2'b10, wd, rd, er);
        chk(tag, 64'(er), 64'd0);
    endtask

    task automatic rd_exp(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic er;
        access(1'b0, a, 2'b10, 32'h0, rd, er);
        chk(tag, {31'd0, er, rd}, {32'd0, exp});
    endtask

    task automatic t_reset;
        chk("R1 cl_rst_o", 64'(cl_rst_o), 64'd0);
        chk("R1 cl_cfg_o", 64'(cl_cfg_o), 64'h10000_00000);
        chk("R1 led_o", 64'(led_o), 64'd0);
        chk("R1 sys_rst_req_o", 64'(sys_rst_req_o), 64'd0);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R2 req_ready", 64'(req_ready), 64'd1);
        rd_exp("R7 staged0 reset", 12'h024, 32'h0);
        rd_exp("R7 staged1 reset", 12'h02C, 32'h10000);
        @(negedge clk);
        chk("R2 idle no rsp", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_hold_status;
        wr_ok("R5 write hold0", 12'h000, 32'hFFFF_FFFF);
        chk("R5 cl_rst_o", 64'(cl_rst_o), 64'h001FF);
        rd_exp("R5 hold0 readback", 12'h000, 32'h1FF);
        rd_exp("R5 hold1 readback", 12'h004, 32'h0);
        rd_exp("R6 stat0", 12'h00C, 32'h1FF);
        rd_exp("R6 stat1", 12'h010, 32'h0);
        sys_rst_i = 1'b1;
        rd_exp("R6 stat1 sys", 12'h010, 32'h1FF);
        sys_rst_i = 1'b0;
        wr_ok("R6 write stat0", 12'h00C, 32'h0);
        rd_exp("R6 stat0 after write", 12'h00C, 32'h1FF);
        wr_ok("R5 write hold1", 12'h004, 32'h0000_0003);
        chk("R5 cl_rst_o both", 64'(cl_rst_o), 64'h007FF);
        wr_ok("R5 clear hold1", 12'h004, 32'h0);
    endtask

    task automatic t_cfg_staging;
        wr_ok("R7 stage0", 12'h024, 32'hFFFA_BCDE);
        rd_exp("R7 staged0", 12'h024, 32'hABCDE);
        chk("R7 not applied yet", 64'(cl_cfg_o[19:0]), 64'h0);
        rd_exp("R8 applied0 old", 12'h020, 32'h0);
        wr_ok("R7 release0", 12'h000, 32'h1FE);
        chk("R7 applied on release", 64'(cl_cfg_o[19:0]), 64'hABCDE);
        rd_exp("R8 applied0 new", 12'h020, 32'hABCDE);
        wr_ok("R7 stage0 again", 12'h024, 32'h12345);
        wr_ok("R7 hold bit1 only", 12'h000, 32'h002);
        chk("R7 no release no apply", 64'(cl_cfg_o[19:0]), 64'hABCDE);
        wr_ok("R7 assert0", 12'h000, 32'h001);
        chk("R7 assert no apply", 64'(cl_cfg_o[19:0]), 64'hABCDE);
        wr_ok("R7 release0 again", 12'h000, 32'h000);
        chk("R7 second apply", 64'(cl_cfg_o[19:0]), 64'h12345);
        wr_ok("R8 write applied0", 12'h020, 32'h0);
        rd_exp("R8 applied0 kept", 12'h020, 32'h12345);
        wr_ok("R7 stage1", 12'h02C, 32'hFFFF_FFFF);
        rd_exp("R7 staged1", 12'h02C, 32'hFFFFF);
        chk("R7 cl1 old", 64'(cl_cfg_o[39:20]), 64'h10000);
        wr_ok("R7 assert1", 12'h004, 32'h001);
        wr_ok("R7 release1", 12'h004, 32'h000);
        chk("R7 cl1 applied", 64'(cl_cfg_o[39:20]), 64'hFFFFF);
        rd_exp("R8 applied1", 12'h028, 32'hFFFFF);
        chk("R7 cl0 untouched", 64'(cl_cfg_o[19:0]), 64'h12345);
    endtask

    task automatic t_swrst;
        wr_ok("R9 zero low bits", 12'h008, 32'h0100_0000);
        chk("R9 no pulse", 64'(sys_rst_req_o), 64'd0);
        wr_ok("R9 nonzero", 12'h008, 32'h0000_0001);
        chk("R9 pulse high", 64'(sys_rst_req_o), 64'd1);
        @(negedge clk);
        chk("R9 pulse one cycle", 64'(sys_rst_req_o), 64'd0);
        rd_exp("R9 read zero", 12'h008, 32'h0);
    endtask

    task automatic t_led_sw;
        wr_ok("R10 led write", 12'h104, 32'h0000_01A5);
        chk("R10 led_o", 64'(led_o), 64'hA5);
        rd_exp("R10 led readback", 12'h104, 32'hA5);
        sw_i = 8'h3C;
        rd_exp("R10 switch read", 12'h108, 32'h3C);
        wr_ok("R10 switch write", 12'h108, 32'hFF);
        rd_exp("R10 switch unchanged", 12'h108, 32'h3C);
        chk("R10 led unchanged", 64'(led_o), 64'hA5);
    endtask

    task automatic t_ids;
        rd_exp("R11 aux id", 12'hFF8, T_AUX_ID);
        rd_exp("R11 main id", 12'hFFC, T_MAIN_ID);
    endtask

    task automatic t_errors;
        logic [31:0] rd; logic er;
        access(1'b0, 12'h030, 2'b10, 32'h0, rd, er);
        chk("R3 undefined read", {31'd0, er, rd}, {31'd0, 1'b1, 32'h0});
        access(1'b1, 12'hFF0, 2'b10, 32'hFFFF_FFFF, rd, er);
        chk("R3 undefined write", 64'(er), 64'd1);
        access(1'b1, 12'h104, 2'b01, 32'h0000_0011, rd, er);
        chk("R4 halfword write err", 64'(er), 64'd1);
        chk("R4 led kept", 64'(led_o), 64'hA5);
        access(1'b0, 12'h104, 2'b00, 32'h0, rd, er);
        chk("R4 byte read err", {31'd0, er, rd}, {31'd0, 1'b1, 32'h0});
        access(1'b1, 12'h001, 2'b10, 32'h1FF, rd, er);
        chk("R4 misaligned err", 64'(er), 64'd1);
        chk("R4 hold kept", 64'(cl_rst_o), 64'h0);
        access(1'b1, 12'h026, 2'b10, 32'h0, rd, er);
        chk("R4 misaligned cfg err", 64'(er), 64'd1);
        rd_exp("R3 staged0 kept", 12'h024, 32'h12345);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hold_status();
        t_cfg_staging();
        t_swrst();
        t_led_sw();
        t_ids();
        t_errors();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule